// File: doc/BRIEF.md
# Serial-Controlled 64-Tap Wiper Controller

This block is the digital core of a digitally controlled potentiometer with 64 tap positions. A host drives it through an SPI-style serial port (SCK, active-low chip select, SI, SO). The block holds a volatile wiper register and four data registers that act as the stored settings. Its output is a 64-line one-hot tap select that closes exactly one switch of the resistor ladder. The serial pins come in with the system clock. The block samples them on that clock and finds the SCK edges itself.

Each transaction starts with an address byte that must carry the block's identifier and match the `a0` strap. An instruction byte follows. Depending on the opcode, a data byte then follows, or the transaction ends, or a stream of single-bit steps follows. With these instructions the host can read or write the wiper, read or write any data register, copy a data register into the wiper, copy the wiper into a data register, and nudge the wiper up or down one tap per clock pulse. After reset, data register 0 is recalled into the wiper.

Top module: `potwiper_ctrl`

## Requirements
- R1: After reset the data registers hold their parameter values (default: register 0 = 20, 1 = 0, 2 = 63, 3 = 5). In the first cycle after reset the wiper is loaded from data register 0.
- R2: The first byte of a frame must have 4'b0101 in bits 7:4 and must have bit 0 equal to `a0`. If it does not, the rest of the frame changes no register and `so_oe` stays low.
- R3: The second byte is the instruction. Bits 7:4 are the opcode: 1001 read wiper, 1010 write wiper, 1011 read data register, 1100 write data register, 1101 data register to wiper, 1110 wiper to data register, 0010 step. Bits 3:2 select the data register, and bits 1:0 have no effect.
- R4: A write takes a third byte. The low 6 bits of that byte go to the target register, and the upper two bits are dropped.
- R5: A read returns the target register in the third byte. The data is zero-extended to 8 bits and sent MSB first, and `so` changes after falling SCK edges. `so_oe` is high only from the falling edge after the instruction until the falling edge after the eighth data bit, or until CS rises.
- R6: The two transfer instructions take effect at the end of the instruction byte and need no data byte.
- R7: After the step instruction, SI is sampled on each rising SCK edge. SI = 1 moves the wiper up one tap, and SI = 0 moves it down one tap.
- R8: A step up at 63 and a step down at 0 leave the wiper unchanged.
- R9: Raising CS ends the frame. A write that stops before its 24th bit changes no register, and while CS is high the wiper does not change.
- R10: `tap_sel` always has exactly one bit set, at the wiper's index. It changes only in the cycle after the wiper changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Active-low synchronous reset |
| sck | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low frame select |
| si | input | 1 | Serial data in, sampled on rising SCK |
| a0 | input | 1 | Address strap compared with bit 0 of the first byte |
| so | output | 1 | Serial read data |
| so_oe | output | 1 | Output enable for the `so` driver |
| tap_sel | output | 64 | One-hot wiper tap select |

## Verification
The checker tests these properties on every cycle:
- `tap_sel` stays one-hot.
- `tap_sel` holds still when the wiper did not move in the previous cycle.
- A step at either end tap leaves the wiper in place.
- The wiper is frozen while CS is high.
- The output enable drops after CS rises.

Only the bench scenarios can show the rest:
- The encoding of the frame.
- The data returned by each read.
- The effect of each transfer.
- That a truncated write or a mismatched address or identifier leaves the registers untouched.

The bench shows these by reading the registers back through the serial port.

// File: rtl/potwiper_ctrl.sv
module potwiper_ctrl #(
  parameter int TAPS = 64,
  parameter logic [3:0] DEV_ID = 4'b0101,
  parameter logic [4*$clog2(TAPS)-1:0] DR_INIT = {6'd5, 6'd63, 6'd0, 6'd20}
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sck,
  input  logic            cs_n,
  input  logic            si,
  input  logic            a0,
  output logic            so,
  output logic            so_oe,
  output logic [TAPS-1:0] tap_sel
);
  localparam int WB = $clog2(TAPS);
  localparam logic [WB-1:0] TOP = WB'(TAPS - 1);
  localparam logic [3:0] OP_RDW = 4'b1001, OP_WRW = 4'b1010, OP_RDD = 4'b1011,
                         OP_WRD = 4'b1100, OP_D2W = 4'b1101, OP_W2D = 4'b1110,
                         OP_STEP = 4'b0010;

  logic sck_r, sck_p, si_r, cs_r;
  logic [4:0] cnt;
  logic [7:0] sh, cmd, osh;
  logic bad, recall;
  logic [WB-1:0] wcr;
  logic [WB-1:0] dr [4];

  always_ff @(posedge clk) begin
    if (!rst_n) {sck_r, sck_p, si_r, cs_r} <= 4'b0001;
    else begin
      sck_r <= sck;
      sck_p <= sck_r;
      si_r  <= si;
      cs_r  <= cs_n;
    end
  end

  wire       rise = !cs_r && sck_r && !sck_p;
  wire       fall = !cs_r && !sck_r && sck_p;
  wire [7:0] nxt  = {sh[6:0], si_r};
  wire [3:0] op   = cmd[7:4];
  wire [1:0] sel  = cmd[3:2];
  wire       is_rd = (op == OP_RDW) || (op == OP_RDD);
  wire       stepping = rise && !bad && op == OP_STEP && cnt == 5'd16;
  wire       inc_ev = stepping && si_r;
  wire       dec_ev = stepping && !si_r;
  wire       last_wr = rise && !bad && cnt == 5'd23;
  wire       instr_done = rise && !bad && cnt == 5'd15;
  wire [7:0] rd_val = {{(8-WB){1'b0}}, (op == OP_RDW) ? wcr : dr[sel]};

  always_ff @(posedge clk) begin
    if (!rst_n || cs_r) begin
      cnt <= '0; sh <= '0; cmd <= '0; bad <= 1'b0; osh <= '0; so_oe <= 1'b0;
    end else begin
      if (rise) begin
        sh <= nxt;
        if (cnt == 5'd7) bad <= (nxt[7:4] != DEV_ID) || (nxt[0] != a0);
        if (cnt == 5'd15) cmd <= nxt;
        if (cnt < 5'd24 && !(cnt == 5'd16 && op == OP_STEP)) cnt <= cnt + 5'd1;
      end
      if (fall && !bad && is_rd) begin
        if (cnt == 5'd16) begin
          so_oe <= 1'b1;
          osh   <= rd_val;
        end else if (cnt == 5'd24) so_oe <= 1'b0;
        else if (cnt > 5'd16) osh <= {osh[6:0], 1'b0};
      end
    end
  end

  assign so = osh[7];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wcr    <= '0;
      recall <= 1'b1;
      for (int i = 0; i < 4; i++) dr[i] <= DR_INIT[i*WB +: WB];
    end else begin
      recall <= 1'b0;
      if (recall) wcr <= dr[0];
      else if (inc_ev) begin
        if (wcr != TOP) wcr <= wcr + 1'b1;
      end else if (dec_ev) begin
        if (wcr != '0) wcr <= wcr - 1'b1;
      end else if (last_wr && op == OP_WRW) wcr <= nxt[WB-1:0];
      else if (instr_done && nxt[7:4] == OP_D2W) wcr <= dr[nxt[3:2]];
      if (last_wr && op == OP_WRD) dr[sel] <= nxt[WB-1:0];
      if (instr_done && nxt[7:4] == OP_W2D) dr[nxt[3:2]] <= wcr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) tap_sel <= {{(TAPS-1){1'b0}}, 1'b1};
    else tap_sel <= {{(TAPS-1){1'b0}}, 1'b1} << wcr;
  end
endmodule

// File: rtl/potwiper_ctrl_chk.sv
module potwiper_ctrl_chk #(
  parameter int TAPS = 64
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     cs_r,
  input logic                     recall,
  input logic                     inc_ev,
  input logic                     dec_ev,
  input logic                     so_oe,
  input logic [$clog2(TAPS)-1:0]  wcr,
  input logic [TAPS-1:0]          tap_sel
);
  localparam logic [$clog2(TAPS)-1:0] TOP = $clog2(TAPS)'(TAPS - 1);

  assert_tap_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(tap_sel) == 1);
  assert_tap_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(wcr) |=> $stable(tap_sel));
  assert_sat_top_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_ev && wcr == TOP) |=> wcr == TOP);
  assert_sat_bottom_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_ev && wcr == '0) |=> wcr == '0);
  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_r && !recall) |=> $stable(wcr));
  assert_oe_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cs_r |=> !so_oe);
endmodule

bind potwiper_ctrl potwiper_ctrl_chk #(.TAPS(TAPS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_r(cs_r), .recall(recall), .inc_ev(inc_ev),
  .dec_ev(dec_ev), .so_oe(so_oe), .wcr(wcr), .tap_sel(tap_sel)
);

// File: tb/potwiper_ctrl_test.sv
module potwiper_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 4;
  localparam int NVEC = 5;
  localparam logic [7:0] VEC [NVEC] = '{8'hFF, 8'h00, 8'h2A, 8'hC5, 8'h7F};

  logic clk = 0, rst_n = 0, sck = 0, cs_n = 1, si = 0, a0 = 0;
  logic so, so_oe;
  logic [63:0] tap_sel;
  int errors = 0, checks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  potwiper_ctrl uut (.clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
    .a0(a0), .so(so), .so_oe(so_oe), .tap_sel(tap_sel));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic frame(input logic [7:0] b1, input logic [7:0] b2, input logic [7:0] b3,
                       input int nbits, output logic [7:0] rd, output logic oe_seen);
    logic [23:0] w = {b1, b2, b3};
    rd = 8'h00; oe_seen = 1'b0;
    @(negedge clk); cs_n = 0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      si = (i < 24) ? w[23-i] : b3[0];
      repeat (HALF) @(negedge clk);
      if (i >= 16 && i < 24) begin
        rd = {rd[6:0], so};
        oe_seen = oe_seen | so_oe;
      end
      sck = 1;
      repeat (HALF) @(negedge clk);
      sck = 0;
    end
    repeat (HALF) @(negedge clk);
    cs_n = 1;
    repeat (HALF + 2) @(negedge clk);
  endtask

  task automatic rd_reg(input logic [7:0] ins, output logic [7:0] v);
    logic oe;
    frame(8'h50, ins, 8'h00, 24, v, oe);
  endtask

  task automatic wr(input logic [7:0] ins, input logic [7:0] d);
    logic [7:0] v; logic oe;
    frame(8'h50, ins, d, 24, v, oe);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic oe;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R1 recall tap", tap_sel, 64'd1 << 20);
    chk("R5 oe idle", so_oe, 0);
    frame(8'h50, 8'h90, 8'h00, 24, v, oe);
    chk("R1 read wiper", v, 20);
    chk("R5 oe during read", oe, 1);
    chk("R5 oe after frame", so_oe, 0);
    rd_reg(8'hBC, v); chk("R1 R3 dr3 init", v, 5);
    rd_reg(8'hB8, v); chk("R1 R3 dr2 init", v, 63);

    for (int k = 0; k < NVEC; k++) begin
      wr(8'hA0, VEC[k]);
      chk("R10 tap after write", tap_sel, 64'd1 << VEC[k][5:0]);
      rd_reg(8'h90, v);
      chk("R4 R5 wiper readback", v, {2'b00, VEC[k][5:0]});
    end

    wr(8'hC8, 8'h91); rd_reg(8'hB8, v); chk("R4 dr2 write", v, 8'h11);
    rd_reg(8'h93, v); chk("R3 low bits ignored", v, 8'h3F);
    frame(8'h50, 8'hDC, 8'h00, 16, v, oe);
    rd_reg(8'h90, v); chk("R6 dr3 to wiper", v, 5);
    wr(8'hA0, 8'd9);
    frame(8'h50, 8'hE4, 8'h00, 16, v, oe);
    rd_reg(8'hB4, v); chk("R6 wiper to dr1", v, 9);

    wr(8'hA0, 8'd10);
    frame(8'h50, 8'h20, 8'hFF, 19, v, oe);
    rd_reg(8'h90, v); chk("R7 step up x3", v, 13);
    frame(8'h50, 8'h20, 8'h00, 18, v, oe);
    rd_reg(8'h90, v); chk("R7 step down x2", v, 11);
    wr(8'hA0, 8'd61);
    frame(8'h50, 8'h20, 8'hFF, 20, v, oe);
    rd_reg(8'h90, v); chk("R8 saturate top", v, 63);
    chk("R10 tap at top", tap_sel, 64'd1 << 63);
    wr(8'hA0, 8'd2);
    frame(8'h50, 8'h20, 8'h00, 19, v, oe);
    rd_reg(8'h90, v); chk("R8 saturate bottom", v, 0);

    wr(8'hA0, 8'd7);
    frame(8'h50, 8'hA0, 8'h21, 20, v, oe);
    rd_reg(8'h90, v); chk("R9 aborted wiper write", v, 7);
    frame(8'h50, 8'hC0, 8'h33, 23, v, oe);
    rd_reg(8'hB0, v); chk("R9 aborted dr0 write", v, 20);

    a0 = 1;
    wr(8'hA0, 8'd40);
    a0 = 0;
    rd_reg(8'h90, v); chk("R2 address mismatch write", v, 7);
    frame(8'h51, 8'h90, 8'h00, 24, v, oe);
    chk("R2 address mismatch read oe", oe, 0);
    frame(8'h70, 8'hA0, 8'd33, 24, v, oe);
    rd_reg(8'h90, v); chk("R2 bad identifier", v, 7);
    a0 = 1;
    frame(8'h51, 8'hA0, 8'd44, 24, v, oe);
    a0 = 0;
    rd_reg(8'h90, v); chk("R2 matching a0=1", v, 44);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule